// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port with Collision and Mode-Fault Detection

This block moves one 8-bit byte each way at once over a four-wire synchronous serial link: a clock, a select line, and one data line per direction. Software reaches it through a small register port. It writes a control register to choose the role (clock source or clock follower), the idle level of the clock, the clock phase and the bit rate. It then writes the data register and reads the received byte back from the same address. Bits travel most significant first.

As the clock source, the block makes the serial clock by dividing the system clock by 4, 8, 16 or 32. As the follower, it shifts on an external clock while its select input is held low. Those inputs pass through two-stage synchronizers, so the external clock must run well below the system clock. Two faults are detected. A data write during a transfer raises a write-collision flag and is dropped. If the select input goes low while the block is the clock source, another device is trying to drive the bus. The block then raises a mode-fault flag, gives up the source role and releases its clock and data drivers.

Register map (2-bit address): 0 = control, 1 = status, 2 = data. Reads are combinational.

Top module: `spi_port`

## Requirements
- R1: After reset the control and status registers read 0, and `sck_oe_o`, `mosi_oe_o` and `miso_oe_o` are all 0.
- R2: With control bit0 (enable) and bit1 (source role) set, a write to the data register starts a transfer of exactly 16 clock edges. The byte leaves on `mosi_o` MSB first, the byte on `miso_i` is captured MSB first, and at the end status bit0 (done) is set and the data register reads the captured byte.
- R3: Control bits 5:4 pick the rate: 0, 1, 2 and 3 give a serial clock period of 4, 8, 16 and 32 system clocks. The first clock edge comes half a period after the data write, and the last one 8 periods after it.
- R4: Control bit2 is the clock idle level, which `sck_o` holds whenever no transfer is running. Control bit3 is the phase. With phase 0, data is captured on the leading edge and changed on the trailing edge, and the first bit is valid before the first edge. With phase 1, data is changed on the leading edge and captured on the trailing edge.
- R5: A read of the data register clears the done flag.
- R6: A data write while a transfer is busy sets status bit1 (collision) and leaves the transfer unchanged. Writing 1 to status bit1 clears it.
- R7: If `ss_ni` is low while the block is enabled as clock source, status bit2 (mode fault) is set and control bit1 is cleared by the third clock edge, after which `sck_oe_o` and `mosi_oe_o` are 0. Writing 1 to status bit2 clears the flag.
- R8: Enabled with control bit1 clear, the block drives `miso_oe_o` only while `ss_ni` is low. It shifts the byte last written to the data register out on `miso_o` and captures `mosi_i`, MSB first, using the polarity and phase of R4 on `sck_i`, and sets done after 8 bits.
- R9: With control bit0 clear, a data write starts nothing, done stays 0 and all three output enables stay 0.
- R10: In the clock-source role `sck_oe_o` and `mosi_oe_o` are 1 and `miso_oe_o` is 0. The clock and the follower data enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| sck_i | input | 1 | Serial clock in (follower role) |
| sck_o | output | 1 | Serial clock out (source role) |
| sck_oe_o | output | 1 | Serial clock driver enable |
| ss_ni | input | 1 | Select input, active low |
| mosi_i | input | 1 | Source-to-follower data in (follower role) |
| mosi_o | output | 1 | Source-to-follower data out |
| mosi_oe_o | output | 1 | Source-to-follower data driver enable |
| miso_i | input | 1 | Follower-to-source data in (source role) |
| miso_o | output | 1 | Follower-to-source data out |
| miso_oe_o | output | 1 | Follower-to-source data driver enable |

## Verification
In the source role, clock edge k of a transfer shows up k times half a period after the clock edge that takes the data write. Done and the received byte are due on the edge that makes the sixteenth serial edge, 8 periods after the write. The bench counts cycles from the write, samples each output at the falling system-clock edge in between, and compares the edge times and the done flag against those numbers. A mode fault is due three clock edges after `ss_ni` falls, so the bench checks it after four. In the follower role, inputs pass through a two-stage synchronizer and lag by two to three cycles. The bench holds each serial level for eight cycles and samples `miso_o` and the flags only at the end of each hold.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DATA_W  = 8;
  localparam int HALF_W  = 5;          // holds the largest half period (16)
  localparam int EDGES   = 2 * DATA_W;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int DONE_BIT = 0;
  localparam int WCOL_BIT = 1;
  localparam int MODF_BIT = 2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int HALF_W = 5,
  parameter int EDGES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              run_o,
  output logic              lead_o,
  output logic              trail_o,
  output logic              phase_o
);
  localparam int                ECNT_W = $clog2(EDGES);
  localparam logic [ECNT_W-1:0] ELAST  = ECNT_W'(EDGES - 1);
  localparam logic [HALF_W-1:0] ONE    = HALF_W'(1);

  logic [HALF_W-1:0] cnt_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic              run_q, phase_q, tick;

  assign tick = run_q && (cnt_q == half_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ecnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (abort_i) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ecnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      ecnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      ecnt_q  <= ecnt_q + ECNT_W'(1);
      if (ecnt_q == ELAST) run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // even edges lead away from idle, odd edges return to it
  assign lead_o  = tick & ~phase_q;
  assign trail_o = tick & phase_q;
  assign run_o   = run_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         cpha_i,
  input  logic         sin_i,
  output logic         sout_o,
  output logic         done_o,
  output logic [W-1:0] rx_next_o
);
  localparam int               CNT_W = $clog2(2 * W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(2 * W - 1);

  logic [W-1:0]     tx_q, rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_any, sample, shift;

  assign edge_any  = lead_i | trail_i;
  assign sample    = (lead_i & ~cpha_i) | (trail_i & cpha_i);
  // phase 1 keeps the first bit on the first leading edge
  assign shift     = (trail_i & ~cpha_i) | (lead_i & cpha_i & (cnt_q != '0));
  assign rx_next_o = sample ? {rx_q[W-2:0], sin_i} : rx_q;
  assign done_o    = edge_any && !load_i && !clear_i && (cnt_q == LAST);
  assign sout_o    = tx_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (edge_any) begin
      cnt_q <= cnt_q + CNT_W'(1);
      rx_q  <= rx_next_o;
      if (shift) tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int DW = spi_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          ss_ni,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe_o
);
  ctrl_t             ctrl_q;
  logic              done_q, wcol_q, modf_q;
  logic [DW-1:0]     rx_buf_q;
  logic              sck_prev_q;

  logic              en, master_bit, cpol_bit, is_master, is_slave;
  logic              ss_s, mosi_s, sck_s, ss_act;
  logic              wr_ctrl, wr_stat, wr_data, rd_data;
  logic              busy, modf_set, start_m, load, wcol_set;
  logic              m_run, m_lead, m_trail, m_phase;
  logic              s_tog, s_lead, s_trail;
  logic              sh_out, xfer_done;
  logic [DW-1:0]     rx_next;
  logic [HALF_W-1:0] half;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   ({ss_s, mosi_s, sck_s})
  );

  assign en         = ctrl_q.en;
  assign master_bit = ctrl_q.master;
  assign cpol_bit   = ctrl_q.cpol;
  assign is_master  = en & master_bit;
  assign is_slave   = en & ~master_bit;
  assign ss_act     = ~ss_s;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign wr_data = wr_i && (addr_i == ADDR_DATA);
  assign rd_data = rd_i && (addr_i == ADDR_DATA);

  assign busy     = is_master ? m_run : (is_slave & ss_act);
  assign modf_set = is_master & ss_act;
  assign wcol_set = wr_data & busy;
  assign load     = wr_data & en & ~busy & ~modf_set;
  assign start_m  = load & is_master;
  assign half     = HALF_W'(2) << ctrl_q.rate;

  spi_clkgen #(.HALF_W(HALF_W), .EDGES(EDGES)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_m),
    .abort_i(~is_master | modf_set),
    .half_i (half),
    .run_o  (m_run),
    .lead_o (m_lead),
    .trail_o(m_trail),
    .phase_o(m_phase)
  );

  // follower edges from the synchronized external clock
  assign s_tog   = sck_s ^ sck_prev_q;
  assign s_lead  = is_slave & ss_act & s_tog & (sck_s != cpol_bit);
  assign s_trail = is_slave & ss_act & s_tog & (sck_s == cpol_bit);

  spi_shifter #(.W(DW)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (~busy),
    .load_i     (load),
    .load_data_i(wdata_i),
    .lead_i     (m_lead | s_lead),
    .trail_i    (m_trail | s_trail),
    .cpha_i     (ctrl_q.cpha),
    .sin_i      (is_master ? miso_i : mosi_s),
    .sout_o     (sh_out),
    .done_o     (xfer_done),
    .rx_next_o  (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      done_q     <= 1'b0;
      wcol_q     <= 1'b0;
      modf_q     <= 1'b0;
      rx_buf_q   <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (modf_set) ctrl_q.master <= 1'b0;   // fault wins over a write

      if (xfer_done) begin
        done_q   <= 1'b1;
        rx_buf_q <= rx_next;
      end else if (rd_data) begin
        done_q <= 1'b0;
      end

      if (wcol_set) wcol_q <= 1'b1;
      else if (wr_stat && wdata_i[WCOL_BIT]) wcol_q <= 1'b0;

      if (modf_set) modf_q <= 1'b1;
      else if (wr_stat && wdata_i[MODF_BIT]) modf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: begin
        rdata_o[DONE_BIT] = done_q;
        rdata_o[WCOL_BIT] = wcol_q;
        rdata_o[MODF_BIT] = modf_q;
      end
      ADDR_DATA: rdata_o = rx_buf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign sck_o     = cpol_bit ^ m_phase;
  assign sck_oe_o  = is_master;
  assign mosi_o    = sh_out;
  assign mosi_oe_o = is_master;
  assign miso_o    = sh_out;
  assign miso_oe_o = is_slave & ss_act;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic cpol_i,
  input logic busy_i,
  input logic sck_i,
  input logic sck_oe_i,
  input logic mosi_oe_i,
  input logic miso_oe_i,
  input logic modf_i,
  input logic wcol_i,
  input logic done_i,
  input logic rd_data_i,
  input logic xfer_done_i
);
  AST_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_oe_i && miso_oe_i)); // R10

  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!sck_oe_i && !mosi_oe_i && !miso_oe_i)); // R9

  AST_MODF_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf_i) |-> !master_i); // R7

  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && !busy_i) |-> (sck_i == cpol_i)); // R4

  AST_WCOL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_i) |-> $past(busy_i)); // R6

  AST_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !xfer_done_i) |=> !done_i); // R5
endmodule

bind spi_port spi_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en),
  .master_i   (master_bit),
  .cpol_i     (cpol_bit),
  .busy_i     (busy),
  .sck_i      (sck_o),
  .sck_oe_i   (sck_oe_o),
  .mosi_oe_i  (mosi_oe_o),
  .miso_oe_i  (miso_oe_o),
  .modf_i     (modf_q),
  .wcol_i     (wcol_q),
  .done_i     (done_q),
  .rd_data_i  (rd_data),
  .xfer_done_i(xfer_done)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       sck_i = 1'b0, sck_o, sck_oe_o;
  logic       ss_ni = 1'b1;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe_o;
  logic       miso_i = 1'b0, miso_o, miso_oe_o;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  always #4 clk_i = ~clk_i;   // 125 MHz

  spi_port dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic data_read(output logic [7:0] d);
    @(negedge clk_i);
    addr_i = A_DATA; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    reg_read(A_CTRL, d);
    check(d == 8'h00, "R1", "ctrl after reset", d, 0);
    reg_read(A_STAT, d);
    check(d == 8'h00, "R1", "status after reset", d, 0);
    check({sck_oe_o, mosi_oe_o, miso_oe_o} == 3'b000, "R1", "enables after reset",
          {sck_oe_o, mosi_oe_o, miso_oe_o}, 0);
  endtask

  // bench plays the follower against the block's clock
  task automatic master_xfer(input bit cpol, input bit cpha, input logic [1:0] rate,
                             input logic [7:0] tx, input logic [7:0] sl, input bit inject);
    int div, half, edges, first, last, lead_idx, trail_idx;
    logic prev;
    logic [7:0] got, d;
    div = 4 << rate; half = div / 2;
    edges = 0; first = -1; last = -1; lead_idx = 0; trail_idx = 1; got = 8'h00;
    reg_write(A_CTRL, {2'b00, rate, cpha, cpol, 2'b11});
    check(sck_o == cpol, "R4", "idle clock level", sck_o, cpol);
    check({sck_oe_o, mosi_oe_o, miso_oe_o} == 3'b110, "R10", "source enables",
          {sck_oe_o, mosi_oe_o, miso_oe_o}, 3'b110);
    miso_i = cpha ? 1'b0 : sl[7];
    reg_write(A_DATA, tx);
    prev = sck_o;
    for (int n = 1; n <= 8 * div + 8; n++) begin
      @(negedge clk_i);
      wr_i = inject && (n == 10);
      addr_i = A_DATA; wdata_i = ~tx;
      if (sck_o != prev) begin
        edges++;
        if (first < 0) first = n;
        last = n;
        if (sck_o != cpol) begin
          if (!cpha) got = {got[6:0], mosi_o};
          else begin
            if (lead_idx < 8) miso_i = sl[7 - lead_idx];
            lead_idx++;
          end
        end else begin
          if (cpha) got = {got[6:0], mosi_o};
          else begin
            if (trail_idx < 8) miso_i = sl[7 - trail_idx];
            trail_idx++;
          end
        end
      end
      prev = sck_o;
    end
    wr_i = 1'b0;
    check(edges == 16, "R2", "serial clock edge count", edges, 16);
    check(first == half, "R3", "first edge delay", first, half);
    check(last == 8 * div, "R3", "last edge delay", last, 8 * div);
    check(got == tx, inject ? "R6" : "R2", "bits sent MSB first", got, tx);
    check(sck_o == cpol, "R4", "clock back at idle", sck_o, cpol);
    reg_read(A_STAT, d);
    check(d[0] == 1'b1, "R2", "done after transfer", d[0], 1);
    check(d[1] == inject, "R6", "collision flag", d[1], inject);
    data_read(d);
    check(d == sl, "R2", "received byte", d, sl);
    reg_read(A_STAT, d);
    check(d[0] == 1'b0, "R5", "done cleared by data read", d[0], 0);
    if (inject) begin
      reg_write(A_STAT, 8'h02);
      reg_read(A_STAT, d);
      check(d[1] == 1'b0, "R6", "collision cleared by write-1", d[1], 0);
    end
  endtask

  // bench plays the clock source against the block
  task automatic slave_xfer(input bit cpol, input bit cpha,
                            input logic [7:0] stx, input logic [7:0] mrx);
    logic [7:0] got, d;
    got = 8'h00;
    ss_ni = 1'b1; sck_i = cpol;
    reg_write(A_CTRL, {4'b0000, cpha, cpol, 2'b01});
    reg_write(A_DATA, stx);
    repeat (4) @(negedge clk_i);
    check(miso_oe_o == 1'b0, "R8", "no drive while deselected", miso_oe_o, 0);
    ss_ni = 1'b0;
    repeat (8) @(negedge clk_i);
    check(miso_oe_o == 1'b1, "R8", "drive while selected", miso_oe_o, 1);
    check(sck_oe_o == 1'b0, "R10", "no clock drive as follower", sck_oe_o, 0);
    for (int i = 0; i < 8; i++) begin
      if (cpha) begin
        sck_i = ~cpol; mosi_i = mrx[7 - i];
        repeat (8) @(negedge clk_i);
        got = {got[6:0], miso_o};
        sck_i = cpol;
        repeat (8) @(negedge clk_i);
      end else begin
        mosi_i = mrx[7 - i];
        repeat (8) @(negedge clk_i);
        got = {got[6:0], miso_o};
        sck_i = ~cpol;
        repeat (8) @(negedge clk_i);
        sck_i = cpol;
      end
    end
    repeat (8) @(negedge clk_i);
    reg_read(A_STAT, d);
    check(d[0] == 1'b1, "R8", "done after 8 follower bits", d[0], 1);
    ss_ni = 1'b1;
    check(got == stx, "R8", "follower bits sent", got, stx);
    data_read(d);
    check(d == mrx, "R8", "follower received byte", d, mrx);
  endtask

  task automatic test_modf();
    logic [7:0] d;
    reg_write(A_CTRL, 8'h03);
    @(negedge clk_i);
    ss_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    reg_read(A_STAT, d);
    check(d[2] == 1'b1, "R7", "mode fault flag", d[2], 1);
    reg_read(A_CTRL, d);
    check(d[1] == 1'b0, "R7", "source bit cleared", d[1], 0);
    check({sck_oe_o, mosi_oe_o} == 2'b00, "R7", "drivers released",
          {sck_oe_o, mosi_oe_o}, 0);
    ss_ni = 1'b1;
    reg_write(A_CTRL, 8'h00);
    reg_write(A_STAT, 8'h04);
    reg_read(A_STAT, d);
    check(d[2] == 1'b0, "R7", "mode fault cleared by write-1", d[2], 0);
  endtask

  task automatic test_disabled();
    logic [7:0] d;
    reg_write(A_CTRL, 8'h02);
    reg_write(A_DATA, 8'h5A);
    ss_ni = 1'b0;
    repeat (40) @(negedge clk_i);
    check({sck_oe_o, mosi_oe_o, miso_oe_o} == 3'b000, "R9", "enables while disabled",
          {sck_oe_o, mosi_oe_o, miso_oe_o}, 0);
    reg_read(A_STAT, d);
    check(d == 8'h00, "R9", "status while disabled", d, 0);
    ss_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    master_xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b1, 1'b1, 2'd1, 8'h96, 8'hC3, 1'b0);
    master_xfer(1'b0, 1'b1, 2'd2, 8'h01, 8'h80, 1'b0);
    master_xfer(1'b1, 1'b0, 2'd3, 8'hFF, 8'h00, 1'b0);
    master_xfer(1'b0, 1'b0, 2'd0, 8'h6B, 8'hD2, 1'b1);
    slave_xfer(1'b0, 1'b0, 8'hB4, 8'h1E);
    slave_xfer(1'b1, 1'b1, 8'h4D, 8'hE7);
    test_modf();
    test_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule